// File: doc/BRIEF.md
# End-of-Frame Receive Status Capture

This block sits beside a serial frame receiver and takes a snapshot of how each received frame ended. When the receiver signals a frame end, either a normal close or an abort, the block stores four things in one status register and raises an interrupt. The stored items are a line-error flag for overrun or framing trouble, a CRC-failure flag, an abort flag and a byte count. The receiver can start on the next frame right away while software reads the stored result of the previous one.

Software services the interrupt in one of two ways. It can read the status register, or it can write a 1 to the interrupt bit of that register. If software is too slow and a second frame ends while the interrupt is still pending, the new result replaces the old one and a sticky overwrite bit records the loss. The byte count stops at the receiver's count at the first line error of the frame. It saturates at 65535.

Top module: `eof_status_latch`

## Requirements
- R1: After reset, `irq_o` is 0 and every bit of `rd_data_o` is 0.
- R2: The count and flag fields (`rd_data_o[18:0]`) change only in the cycle after a frame end, which is `frame_eof_i` or `frame_abort_i` high. In every other cycle they hold their value.
- R3: On a frame end the flags are loaded as follows:
  - bit 16 is set if `line_err_i` was high in any cycle of the frame, including the end cycle;
  - bit 17 takes `crc_bad_i` from the end cycle;
  - bit 18 takes `frame_abort_i` from the end cycle.
- R4: The count field (bits 15:0) is loaded from `byte_cnt_i` as follows:
  - if a line error occurred earlier in the frame, it takes the value seen in the cycle of the first line error;
  - otherwise it takes the value seen in the end cycle.
- R5: When `byte_cnt_i` exceeds 65535, the count field is loaded as 65535.
- R6: `irq_o` is high in the cycle after a frame end.
- R7: A cycle with `rd_en_i` high and no frame end clears `irq_o` and the overwrite bit from the next cycle on.
- R8: A cycle with `wr_en_i` high and `wr_data_i[24]` = 1 clears `irq_o` and the overwrite bit. A write with `wr_data_i[24]` = 0 changes nothing.
- R9: A frame end while `irq_o` is high, with no clear in the same cycle, sets the overwrite bit (`rd_data_o[25]`). The bit stays set until it is cleared.
- R10: When a clear and a frame end fall in the same cycle, the load wins: `irq_o` stays high, the new fields are stored, and the overwrite bit is cleared.
- R11: `rd_data_o` bit 24 mirrors `irq_o`. Bits 23:19 and 31:26 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_eof_i | input | 1 | Frame closed normally (strobe) |
| frame_abort_i | input | 1 | Frame aborted (strobe) |
| line_err_i | input | 1 | Overrun or framing error seen (strobe) |
| crc_bad_i | input | 1 | CRC check failed, valid with frame end |
| byte_cnt_i | input | CNT_IN_W | Receiver's running count of valid bytes |
| rd_en_i | input | 1 | Status register read strobe |
| wr_en_i | input | 1 | Status register write strobe |
| wr_data_i | input | 32 | Write data; bit 24 = 1 clears the interrupt |
| rd_data_o | output | 32 | Status register contents |
| irq_o | output | 1 | Interrupt, high while a result is pending |

## Verification
A wrong frozen-count or error-tracking state has no effect at the ports until the frame ends. It shows up one cycle after the end strobe as a wrong count or flag field. A wrong pending or overwrite state shows on `irq_o` and bit 25 in the very next cycle. It also produces a missing or spurious overwrite at the next frame end. The bench compares the whole register and the interrupt every cycle, so each of these faults is caught within one cycle of the frame end that exposes it.

// File: rtl/fsc_pkg.sv
package fsc_pkg;
  localparam int REG_W    = 32;
  localparam int CNT_FW   = 16;
  localparam int LERR_BIT = 16;
  localparam int CRC_BIT  = 17;
  localparam int ABT_BIT  = 18;
  localparam int IRQ_BIT  = 24;
  localparam int OVW_BIT  = 25;

  typedef struct packed {
    logic              abt;
    logic              crc;
    logic              lerr;
    logic [CNT_FW-1:0] cnt;
  } snap_t;
endpackage

// File: rtl/fsc_rst_sync.sv
module fsc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_n_s = sh_q[STAGES-1];
endmodule

// File: rtl/fsc_err_track.sv
module fsc_err_track
  import fsc_pkg::*;
#(
  parameter int CNT_IN_W = 20
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                line_err_i,
  input  logic                frame_end_i,
  input  logic [CNT_IN_W-1:0] byte_cnt_i,
  output logic                err_flag_o,
  output logic [CNT_FW-1:0]   cnt_o
);
  logic              seen_q, seen_d;
  logic [CNT_FW-1:0] frz_q, frz_d;
  logic [CNT_FW-1:0] sat_cnt;
  logic              frz_en;

  generate
    if (CNT_IN_W > CNT_FW) begin : g_sat
      assign sat_cnt = (|byte_cnt_i[CNT_IN_W-1:CNT_FW]) ? {CNT_FW{1'b1}}
                                                         : byte_cnt_i[CNT_FW-1:0];
    end else if (CNT_IN_W == CNT_FW) begin : g_eq
      assign sat_cnt = byte_cnt_i;
    end else begin : g_ext
      assign sat_cnt = {{(CNT_FW-CNT_IN_W){1'b0}}, byte_cnt_i};
    end
  endgenerate

  // first error of a frame freezes the count (unless the frame ends now)
  always_comb begin
    frz_en = line_err_i & ~seen_q & ~frame_end_i;
    frz_d  = frz_en ? sat_cnt : frz_q;
    if (frame_end_i) seen_d = 1'b0;
    else             seen_d = seen_q | line_err_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      frz_q  <= '0;
    end else begin
      seen_q <= seen_d;
      if (frz_en) frz_q <= frz_d;
    end
  end

  assign err_flag_o = seen_q | line_err_i;
  assign cnt_o      = seen_q ? frz_q : sat_cnt;
endmodule

// File: rtl/fsc_snapshot.sv
module fsc_snapshot
  import fsc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load_i,
  input  snap_t new_i,
  output snap_t snap_o
);
  snap_t snap_q, snap_d;

  always_comb begin
    snap_d = load_i ? new_i : snap_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      snap_q <= '0;
    else if (load_i) snap_q <= snap_d;
  end

  assign snap_o = snap_q;
endmodule

// File: rtl/fsc_irq_ctrl.sv
module fsc_irq_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic clr_i,
  output logic irq_o,
  output logic ovw_o
);
  logic pend_q, pend_d;
  logic ovw_q, ovw_d;

  always_comb begin
    // load has priority over clear
    if (load_i)     pend_d = 1'b1;
    else if (clr_i) pend_d = 1'b0;
    else            pend_d = pend_q;

    // a same-cycle clear counts as servicing the old result
    if (clr_i)                   ovw_d = 1'b0;
    else if (load_i && pend_q)   ovw_d = 1'b1;
    else                         ovw_d = ovw_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      ovw_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      ovw_q  <= ovw_d;
    end
  end

  assign irq_o = pend_q;
  assign ovw_o = ovw_q;
endmodule

// File: rtl/eof_status_latch.sv
module eof_status_latch
  import fsc_pkg::*;
#(
  parameter int CNT_IN_W = 20
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frame_eof_i,
  input  logic                frame_abort_i,
  input  logic                line_err_i,
  input  logic                crc_bad_i,
  input  logic [CNT_IN_W-1:0] byte_cnt_i,
  input  logic                rd_en_i,
  input  logic                wr_en_i,
  input  logic [REG_W-1:0]    wr_data_i,
  output logic [REG_W-1:0]    rd_data_o,
  output logic                irq_o
);
  logic              rst_n_s;
  logic              frame_end;
  logic              clr;
  logic              err_flag;
  logic [CNT_FW-1:0] cap_cnt;
  snap_t             snap_new, snap_cur;
  logic              pend, ovw;

  fsc_rst_sync #(.STAGES(2)) u_rsync (
    .clk(clk), .rst_n(rst_n), .rst_n_s(rst_n_s)
  );

  always_comb begin
    frame_end = frame_eof_i | frame_abort_i;
    clr       = rd_en_i | (wr_en_i & wr_data_i[IRQ_BIT]);
  end

  fsc_err_track #(.CNT_IN_W(CNT_IN_W)) u_err (
    .clk(clk), .rst_n(rst_n_s), .line_err_i(line_err_i),
    .frame_end_i(frame_end), .byte_cnt_i(byte_cnt_i),
    .err_flag_o(err_flag), .cnt_o(cap_cnt)
  );

  always_comb begin
    snap_new.abt  = frame_abort_i;
    snap_new.crc  = crc_bad_i;
    snap_new.lerr = err_flag;
    snap_new.cnt  = cap_cnt;
  end

  fsc_snapshot u_snap (
    .clk(clk), .rst_n(rst_n_s), .load_i(frame_end),
    .new_i(snap_new), .snap_o(snap_cur)
  );

  fsc_irq_ctrl u_irq (
    .clk(clk), .rst_n(rst_n_s), .load_i(frame_end), .clr_i(clr),
    .irq_o(pend), .ovw_o(ovw)
  );

  always_comb begin
    rd_data_o                   = '0;
    rd_data_o[CNT_FW-1:0]       = snap_cur.cnt;
    rd_data_o[LERR_BIT]         = snap_cur.lerr;
    rd_data_o[CRC_BIT]          = snap_cur.crc;
    rd_data_o[ABT_BIT]          = snap_cur.abt;
    rd_data_o[IRQ_BIT]          = pend;
    rd_data_o[OVW_BIT]          = ovw;
  end

  assign irq_o = pend;
endmodule

// File: rtl/fsc_checker.sv
module fsc_checker #(
  parameter int CNT_IN_W = 20
) (
  input logic                clk,
  input logic                rst_n,
  input logic                frame_eof_i,
  input logic                frame_abort_i,
  input logic                rd_en_i,
  input logic                wr_en_i,
  input logic [31:0]         wr_data_i,
  input logic [31:0]         rd_data_o,
  input logic                irq_o
);
  logic fe, wclr;
  assign fe   = frame_eof_i | frame_abort_i;
  assign wclr = wr_en_i & wr_data_i[24];

  assert_irq_after_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fe |=> irq_o);

  assert_fields_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !fe |=> $stable(rd_data_o[18:0]));

  assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && !fe) |=> (!irq_o && !rd_data_o[25]));

  assert_write_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wclr && !fe) |=> (!irq_o && !rd_data_o[25]));

  assert_overwrite_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fe && irq_o && !rd_en_i && !wclr) |=> rd_data_o[25]);

  assert_load_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (fe && (rd_en_i || wclr)) |=> (irq_o && !rd_data_o[25]));
endmodule

bind eof_status_latch fsc_checker #(.CNT_IN_W(CNT_IN_W)) u_chk (
  .clk(clk), .rst_n(rst_n_s), .frame_eof_i(frame_eof_i),
  .frame_abort_i(frame_abort_i), .rd_en_i(rd_en_i), .wr_en_i(wr_en_i),
  .wr_data_i(wr_data_i), .rd_data_o(rd_data_o), .irq_o(irq_o)
);

// File: tb/sim_eof_status_latch.sv
`timescale 1ns/1ps
module sim_eof_status_latch;
  localparam int CW = 20;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          eof, abt, lerr, crc, rd, wr;
  logic [CW-1:0] cnt;
  logic [31:0]   wd;
  logic [31:0]   rdata;
  logic          irq;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  // model of the register contents after the last clock edge
  logic [15:0] m_cnt, m_frz;
  logic        m_lerr, m_crc, m_abt, m_irq, m_ovw, m_seen;

  always #10 clk = ~clk;

  eof_status_latch #(.CNT_IN_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .frame_eof_i(eof), .frame_abort_i(abt),
    .line_err_i(lerr), .crc_bad_i(crc), .byte_cnt_i(cnt),
    .rd_en_i(rd), .wr_en_i(wr), .wr_data_i(wd),
    .rd_data_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] sat16(input logic [CW-1:0] v);
    return (v > 20'd65535) ? 16'hFFFF : v[15:0];
  endfunction

  task automatic compare_all();
    chk("R6 R7 R10 irq", {31'd0, irq}, {31'd0, m_irq});
    chk("R2 R4 R5 count", {16'd0, rdata[15:0]}, {16'd0, m_cnt});
    chk("R3 flags", {29'd0, rdata[18:16]}, {29'd0, m_abt, m_crc, m_lerr});
    chk("R9 overwrite", {31'd0, rdata[25]}, {31'd0, m_ovw});
    chk("R11 layout", {rdata[31:26], rdata[24:19]}, {6'd0, m_irq, 5'd0});
  endtask

  // drive one cycle of inputs, advance the model, compare after the edge
  task automatic step(input logic e, input logic a, input logic le, input logic cb,
                      input logic [CW-1:0] c, input logic r, input logic w,
                      input logic [31:0] d);
    logic fe, clr, n_irq, n_ovw;
    eof = e; abt = a; lerr = le; crc = cb; cnt = c; rd = r; wr = w; wd = d;
    fe  = e | a;
    clr = r | (w & d[24]);
    n_irq = fe ? 1'b1 : (clr ? 1'b0 : m_irq);
    n_ovw = clr ? 1'b0 : ((fe && m_irq) ? 1'b1 : m_ovw);
    if (fe) begin
      m_cnt  = m_seen ? m_frz : sat16(c);
      m_lerr = m_seen | le;
      m_crc  = cb;
      m_abt  = a;
    end
    if (!m_seen && le && !fe) m_frz = sat16(c);
    m_seen = fe ? 1'b0 : (m_seen | le);
    m_irq = n_irq;
    m_ovw = n_ovw;
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle();
    step(0, 0, 0, 0, cnt, 0, 0, 32'd0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [CW-1:0] bc;
    void'($urandom(32'd1234));
    {eof, abt, lerr, crc, rd, wr} = '0;
    cnt = '0; wd = '0;
    m_cnt = '0; m_frz = '0;
    {m_lerr, m_crc, m_abt, m_irq, m_ovw, m_seen} = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset rd_data", rdata, 32'd0);
    chk("R1 reset irq", {31'd0, irq}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 after release", rdata, 32'd0);

    // R4: error freezes count
    step(0, 0, 0, 0, 20'd5, 0, 0, 0);
    step(0, 0, 1, 0, 20'd7, 0, 0, 0);
    step(0, 0, 1, 0, 20'd9, 0, 0, 0);
    step(1, 0, 0, 1, 20'd12, 0, 0, 0);
    chk("R4 frozen count", {16'd0, rdata[15:0]}, 32'd7);
    chk("R3 lerr+crc", {29'd0, rdata[18:16]}, 32'b011);
    chk("R6 irq up", {31'd0, irq}, 32'd1);
    // R8: write with bit24 = 0 is ignored
    step(0, 0, 0, 0, 20'd0, 0, 1, 32'hFEFF_FFFF);
    chk("R8 write zero ignored", {31'd0, irq}, 32'd1);
    // R9: overwrite while pending; R5 saturation
    step(0, 1, 0, 0, 20'd70000, 0, 0, 0);
    chk("R9 overwrite set", {31'd0, rdata[25]}, 32'd1);
    chk("R5 saturated", {16'd0, rdata[15:0]}, 32'd65535);
    chk("R3 abort flag", {31'd0, rdata[18]}, 32'd1);
    idle();
    chk("R9 overwrite sticky", {31'd0, rdata[25]}, 32'd1);
    // R8: write one clears
    step(0, 0, 0, 0, 20'd0, 0, 1, 32'h0100_0000);
    chk("R8 write one clears", {30'd0, rdata[25], irq}, 32'd0);
    // R10: read and frame end together
    step(0, 0, 0, 0, 20'd3, 0, 0, 0);
    step(1, 0, 0, 0, 20'd4, 0, 0, 0);
    step(1, 0, 0, 0, 20'd6, 1, 0, 0);
    chk("R10 load wins", {30'd0, rdata[25], irq}, 32'd1);
    chk("R10 new count", {16'd0, rdata[15:0]}, 32'd6);
    // R7: read clears
    step(0, 0, 0, 0, 20'd0, 1, 0, 0);
    chk("R7 read clears", {30'd0, rdata[25], irq}, 32'd0);
    // R3: error in the end cycle itself counts; count not frozen
    step(1, 0, 1, 0, 20'd65535, 0, 0, 0);
    chk("R3 end-cycle error", {29'd0, rdata[18:16]}, 32'b001);
    chk("R5 at limit", {16'd0, rdata[15:0]}, 32'd65535);

    // constrained random frames
    bc = '0;
    for (int i = 0; i < 4000; i++) begin
      logic e, a, le, cb, r, w;
      logic [31:0] d;
      int p;
      p  = $urandom_range(0, 99);
      e  = (p < 7);
      a  = (p >= 97);
      le = ($urandom_range(0, 99) < 4);
      cb = $urandom_range(0, 1);
      r  = ($urandom_range(0, 99) < 6);
      w  = ($urandom_range(0, 99) < 6);
      d  = $urandom;
      if ($urandom_range(0, 3) != 0) bc = bc + 20'($urandom_range(1, 3));
      if ($urandom_range(0, 199) == 0) bc = 20'd65530;
      step(e, a, le, cb, bc, r, w, d);
      if (e | a) bc = '0;
    end
    idle();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule